// File: doc/BRIEF.md
# Context Descriptor Checker

This block checks a stage-1 context descriptor that has already been fetched from memory. It also turns that descriptor into the configuration that a page table walker uses. The descriptor arrives as a set of decoded fields, together with the implementation's maximum output-size code. A strobe marks the cycle in which these inputs are valid.

The block does the following:

- It checks the header bits.
- It decodes the output address size and caps it at the implementation limit.
- It runs an independent set of checks on each of the two translation tables.
- It reports a verdict one clock after the strobe: either an ok flag or a bad-descriptor event.

The configuration is held in an output register. That register is loaded only when the strobe is high, so a downstream walker can read the configuration until the next descriptor arrives. The configuration is loaded whether the descriptor is accepted or rejected.

Top module: `cd_check`

## Requirements
- R1: The verdict appears in the clock after `in_vld` is sampled high. `out_vld` is high for that one cycle, and exactly one of `cfg_ok` and `bad_cd_evt` is high with it. When `in_vld` was low, all three are low and every configuration output keeps its previous value.
- R2: A descriptor with `cd_valid` low or `cd_fmt64` low is rejected.
- R3: A descriptor is rejected unless `cd_abort` is 1, `cd_stall` is 0, `cd_hw_af` is 0 and `cd_hw_dirty` is 0.
- R4: Size codes map as 0→32, 1→36, 2→40, 3→42, 4→44, 5→48 and 6→52 bits, and code 7 maps to 48. `oas_bits` is the smaller of the decoded `cd_ips` and the decoded `max_ips`.
- R5: When bit i of `cd_walk_dis` is set, table i is skipped by every per-table check, and `tt_dis` bit i reports the disable. The other table is still checked.
- R6: The size field of each enabled table must lie in the range 16 to 39, inclusive.
- R7: Table 0 granule codes are 0=4 KB, 1=64 KB and 2=16 KB. Table 1 granule codes are 1=16 KB, 2=4 KB and 3=64 KB. `gran0` and `gran1` report log2 of the page size (12, 14 or 16), or 0 for a code that is not listed. An enabled table is accepted only with 4 KB or 64 KB.
- R8: `cd_big_endian` set rejects the descriptor when at least one table is enabled. When both tables are disabled, the bit has no effect.
- R9: An enabled table whose base has any bit set at position `oas_bits` or above is rejected.
- R10: `tbi_o`, `asid_o` and `record_o` carry the descriptor's top-byte-ignore, ASID and record bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Descriptor fields valid this cycle |
| cd_valid | input | 1 | Descriptor valid bit |
| cd_fmt64 | input | 1 | 64-bit format bit |
| cd_abort | input | 1 | Abort-on-fault bit |
| cd_stall | input | 1 | Stall bit |
| cd_hw_af | input | 1 | Hardware access-flag update bit |
| cd_hw_dirty | input | 1 | Hardware dirty-state update bit |
| cd_big_endian | input | 1 | Table-walk endianness bit |
| cd_record | input | 1 | Record-translation-faults bit |
| cd_tbi | input | 2 | Top-byte-ignore per table |
| cd_asid | input | ASID_W | Address space identifier |
| cd_ips | input | 3 | Requested output size code |
| max_ips | input | 3 | Implementation maximum output size code |
| cd_walk_dis | input | 2 | Walk-disable bit per table |
| cd_tsz0 | input | TSZ_W | Table 0 size field |
| cd_tsz1 | input | TSZ_W | Table 1 size field |
| cd_tg0 | input | 2 | Table 0 granule code |
| cd_tg1 | input | 2 | Table 1 granule code |
| cd_ttb0 | input | TTB_W | Table 0 base address |
| cd_ttb1 | input | TTB_W | Table 1 base address |
| out_vld | output | 1 | Verdict valid |
| cfg_ok | output | 1 | Descriptor accepted |
| bad_cd_evt | output | 1 | Bad-descriptor event |
| oas_bits | output | 6 | Effective output address size in bits |
| tbi_o | output | 2 | Top-byte-ignore |
| asid_o | output | ASID_W | ASID |
| record_o | output | 1 | Fault-record enable |
| tt_dis | output | 2 | Per-table disable |
| tsz0 | output | TSZ_W | Table 0 size |
| tsz1 | output | TSZ_W | Table 1 size |
| gran0 | output | 5 | Table 0 granule, log2 bytes |
| gran1 | output | 5 | Table 1 granule, log2 bytes |
| base0 | output | TTB_W | Table 0 base |
| base1 | output | TTB_W | Table 1 base |

## Verification
Every result of this block sits one register stage behind its stimulus. The verdict flags and the configuration are both due at the first rising edge after `in_vld` is sampled high.

The bench drives inputs and raises the strobe on a falling edge. It waits for one rising edge and reads the outputs on the next falling edge, so each check lands in the cycle where the value is due. For the hold case, it changes the inputs with the strobe low and checks one cycle later that nothing has moved.

// File: rtl/cdchk_pkg.sv
package cdchk_pkg;

    typedef enum logic [4:0] {
        GR_NONE = 5'd0,
        GR_4K   = 5'd12,
        GR_16K  = 5'd14,
        GR_64K  = 5'd16
    } gran_e;

    localparam int TSZ_LO_C = 16;
    localparam int TSZ_HI_C = 39;

    function automatic logic [5:0] oas_from_code(input logic [2:0] code);
        logic [5:0] bits;
        case (code)
            3'd0:    bits = 6'd32;
            3'd1:    bits = 6'd36;
            3'd2:    bits = 6'd40;
            3'd3:    bits = 6'd42;
            3'd4:    bits = 6'd44;
            3'd5:    bits = 6'd48;
            3'd6:    bits = 6'd52;
            default: bits = 6'd48;
        endcase
        return bits;
    endfunction

    function automatic gran_e gran_decode(input logic hi_tbl, input logic [1:0] tg);
        gran_e g;
        g = GR_NONE;
        if (!hi_tbl) begin
            case (tg)
                2'd0:    g = GR_4K;
                2'd1:    g = GR_64K;
                2'd2:    g = GR_16K;
                default: g = GR_NONE;
            endcase
        end else begin
            case (tg)
                2'd1:    g = GR_16K;
                2'd2:    g = GR_4K;
                2'd3:    g = GR_64K;
                default: g = GR_NONE;
            endcase
        end
        return g;
    endfunction

endpackage

// File: rtl/cd_hdr_chk.sv
module cd_hdr_chk
    import cdchk_pkg::*;
(
    input  logic       desc_valid,
    input  logic       fmt64,
    input  logic       abort_en,
    input  logic       stall_en,
    input  logic       hw_af,
    input  logic       hw_dirty,
    input  logic [2:0] ips_code,
    input  logic [2:0] max_code,
    output logic       hdr_fault,
    output logic [5:0] oas_bits
);
    logic [5:0] want_bits;
    logic [5:0] cap_bits;

    always_comb begin
        want_bits = oas_from_code(ips_code);
        cap_bits  = oas_from_code(max_code);
        oas_bits  = (want_bits < cap_bits) ? want_bits : cap_bits;
        hdr_fault = !desc_valid || !fmt64 || !abort_en || stall_en || hw_af || hw_dirty;
    end
endmodule

// File: rtl/cd_tt_chk.sv
module cd_tt_chk
    import cdchk_pkg::*;
#(
    parameter int TSZ_W  = 6,
    parameter int TTB_W  = 52,
    parameter bit HI_TBL = 1'b0
) (
    input  logic             walk_dis,
    input  logic [TSZ_W-1:0] tsz,
    input  logic [1:0]       tg,
    input  logic [TTB_W-1:0] ttb,
    input  logic [5:0]       oas_bits,
    output gran_e            gran,
    output logic             tt_fault
);
    localparam logic [TSZ_W-1:0] TSZ_LO = TSZ_W'(TSZ_LO_C);
    localparam logic [TSZ_W-1:0] TSZ_HI = TSZ_W'(TSZ_HI_C);

    logic tsz_bad;
    logic gran_bad;
    logic base_bad;

    always_comb begin
        gran     = gran_decode(HI_TBL, tg);
        tsz_bad  = (tsz < TSZ_LO) || (tsz > TSZ_HI);
        gran_bad = !((gran == GR_4K) || (gran == GR_64K));
        base_bad = (ttb >> oas_bits) != '0;
        tt_fault = !walk_dis && (tsz_bad || gran_bad || base_bad);
    end
endmodule

// File: rtl/cd_check.sv
module cd_check
    import cdchk_pkg::*;
#(
    parameter int ASID_W = 16,
    parameter int TSZ_W  = 6,
    parameter int TTB_W  = 52
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld,
    input  logic              cd_valid,
    input  logic              cd_fmt64,
    input  logic              cd_abort,
    input  logic              cd_stall,
    input  logic              cd_hw_af,
    input  logic              cd_hw_dirty,
    input  logic              cd_big_endian,
    input  logic              cd_record,
    input  logic [1:0]        cd_tbi,
    input  logic [ASID_W-1:0] cd_asid,
    input  logic [2:0]        cd_ips,
    input  logic [2:0]        max_ips,
    input  logic [1:0]        cd_walk_dis,
    input  logic [TSZ_W-1:0]  cd_tsz0,
    input  logic [TSZ_W-1:0]  cd_tsz1,
    input  logic [1:0]        cd_tg0,
    input  logic [1:0]        cd_tg1,
    input  logic [TTB_W-1:0]  cd_ttb0,
    input  logic [TTB_W-1:0]  cd_ttb1,
    output logic              out_vld,
    output logic              cfg_ok,
    output logic              bad_cd_evt,
    output logic [5:0]        oas_bits,
    output logic [1:0]        tbi_o,
    output logic [ASID_W-1:0] asid_o,
    output logic              record_o,
    output logic [1:0]        tt_dis,
    output logic [TSZ_W-1:0]  tsz0,
    output logic [TSZ_W-1:0]  tsz1,
    output logic [4:0]        gran0,
    output logic [4:0]        gran1,
    output logic [TTB_W-1:0]  base0,
    output logic [TTB_W-1:0]  base1
);
    localparam int NTBL = 2;

    logic             hdr_fault;
    logic [5:0]       oas_c;
    logic [TSZ_W-1:0] tsz_a [NTBL];
    logic [1:0]       tg_a  [NTBL];
    logic [TTB_W-1:0] ttb_a [NTBL];
    gran_e            gran_a [NTBL];
    logic [NTBL-1:0]  tt_fault;
    logic             endian_fault;
    logic             accept;

    assign tsz_a[0] = cd_tsz0;
    assign tsz_a[1] = cd_tsz1;
    assign tg_a[0]  = cd_tg0;
    assign tg_a[1]  = cd_tg1;
    assign ttb_a[0] = cd_ttb0;
    assign ttb_a[1] = cd_ttb1;

    cd_hdr_chk u_hdr (
        .desc_valid (cd_valid),
        .fmt64      (cd_fmt64),
        .abort_en   (cd_abort),
        .stall_en   (cd_stall),
        .hw_af      (cd_hw_af),
        .hw_dirty   (cd_hw_dirty),
        .ips_code   (cd_ips),
        .max_code   (max_ips),
        .hdr_fault  (hdr_fault),
        .oas_bits   (oas_c)
    );

    for (genvar g = 0; g < NTBL; g++) begin : g_tbl
        cd_tt_chk #(
            .TSZ_W  (TSZ_W),
            .TTB_W  (TTB_W),
            .HI_TBL (g == 1)
        ) u_tt (
            .walk_dis (cd_walk_dis[g]),
            .tsz      (tsz_a[g]),
            .tg       (tg_a[g]),
            .ttb      (ttb_a[g]),
            .oas_bits (oas_c),
            .gran     (gran_a[g]),
            .tt_fault (tt_fault[g])
        );
    end

    always_comb begin
        endian_fault = cd_big_endian && (cd_walk_dis != '1);
        accept       = !hdr_fault && (tt_fault == '0) && !endian_fault;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld    <= 1'b0;
            cfg_ok     <= 1'b0;
            bad_cd_evt <= 1'b0;
            oas_bits   <= '0;
            tbi_o      <= '0;
            asid_o     <= '0;
            record_o   <= 1'b0;
            tt_dis     <= '0;
            tsz0       <= '0;
            tsz1       <= '0;
            gran0      <= '0;
            gran1      <= '0;
            base0      <= '0;
            base1      <= '0;
        end else begin
            out_vld    <= in_vld;
            cfg_ok     <= in_vld && accept;
            bad_cd_evt <= in_vld && !accept;
            if (in_vld) begin
                oas_bits <= oas_c;
                tbi_o    <= cd_tbi;
                asid_o   <= cd_asid;
                record_o <= cd_record;
                tt_dis   <= cd_walk_dis;
                tsz0     <= cd_tsz0;
                tsz1     <= cd_tsz1;
                gran0    <= gran_a[0];
                gran1    <= gran_a[1];
                base0    <= cd_ttb0;
                base1    <= cd_ttb1;
            end
        end
    end
endmodule

// File: rtl/cd_check_sva.sv
module cd_check_sva #(
    parameter int TSZ_W = 6,
    parameter int TTB_W = 52
) (
    input logic             clk,
    input logic             rst,
    input logic             in_vld,
    input logic             out_vld,
    input logic             cfg_ok,
    input logic             bad_cd_evt,
    input logic [5:0]       oas_bits,
    input logic [1:0]       tt_dis,
    input logic [TSZ_W-1:0] tsz0,
    input logic [TSZ_W-1:0] tsz1,
    input logic [4:0]       gran0,
    input logic [4:0]       gran1,
    input logic [TTB_W-1:0] base0,
    input logic [TTB_W-1:0] base1
);
    // R1
    vld_follow_chk: assert property (@(posedge clk) disable iff (rst) in_vld |=> out_vld);
    // R1
    vld_idle_chk: assert property (@(posedge clk) disable iff (rst) !in_vld |=> !out_vld);
    // R1
    one_verdict_chk: assert property (@(posedge clk) disable iff (rst) out_vld |-> (cfg_ok != bad_cd_evt));
    // R1
    quiet_chk: assert property (@(posedge clk) disable iff (rst) !out_vld |-> (!cfg_ok && !bad_cd_evt));
    // R1
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> ($stable(oas_bits) && $stable(base0) && $stable(base1) && $stable(tt_dis)));
    // R6
    tsz_range_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_ok |-> ((tt_dis[0] || (tsz0 >= TSZ_W'(16) && tsz0 <= TSZ_W'(39))) &&
                    (tt_dis[1] || (tsz1 >= TSZ_W'(16) && tsz1 <= TSZ_W'(39)))));
    // R7
    gran_ok_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_ok |-> ((tt_dis[0] || gran0 == 5'd12 || gran0 == 5'd16) &&
                    (tt_dis[1] || gran1 == 5'd12 || gran1 == 5'd16)));
    // R9
    base_fit_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_ok |-> ((tt_dis[0] || (base0 >> oas_bits) == '0) &&
                    (tt_dis[1] || (base1 >> oas_bits) == '0)));
endmodule

bind cd_check cd_check_sva #(.TSZ_W(TSZ_W), .TTB_W(TTB_W)) u_cd_check_sva (
    .clk        (clk),
    .rst        (rst),
    .in_vld     (in_vld),
    .out_vld    (out_vld),
    .cfg_ok     (cfg_ok),
    .bad_cd_evt (bad_cd_evt),
    .oas_bits   (oas_bits),
    .tt_dis     (tt_dis),
    .tsz0       (tsz0),
    .tsz1       (tsz1),
    .gran0      (gran0),
    .gran1      (gran1),
    .base0      (base0),
    .base1      (base1)
);

// File: tb/cd_check_bench.sv
`timescale 1ns/1ps
module cd_check_bench;
    localparam int ASID_W = 16;
    localparam int TSZ_W  = 6;
    localparam int TTB_W  = 52;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_vld = 1'b0;
    logic cd_valid, cd_fmt64, cd_abort, cd_stall, cd_hw_af, cd_hw_dirty;
    logic cd_big_endian, cd_record;
    logic [1:0] cd_tbi;
    logic [ASID_W-1:0] cd_asid;
    logic [2:0] cd_ips, max_ips;
    logic [1:0] cd_walk_dis;
    logic [TSZ_W-1:0] cd_tsz0, cd_tsz1;
    logic [1:0] cd_tg0, cd_tg1;
    logic [TTB_W-1:0] cd_ttb0, cd_ttb1;

    logic out_vld, cfg_ok, bad_cd_evt, record_o;
    logic [5:0] oas_bits;
    logic [1:0] tbi_o, tt_dis;
    logic [ASID_W-1:0] asid_o;
    logic [TSZ_W-1:0] tsz0, tsz1;
    logic [4:0] gran0, gran1;
    logic [TTB_W-1:0] base0, base1;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    cd_check #(.ASID_W(ASID_W), .TSZ_W(TSZ_W), .TTB_W(TTB_W)) u_cd_check (
        .clk(clk), .rst(rst), .in_vld(in_vld),
        .cd_valid(cd_valid), .cd_fmt64(cd_fmt64), .cd_abort(cd_abort), .cd_stall(cd_stall),
        .cd_hw_af(cd_hw_af), .cd_hw_dirty(cd_hw_dirty), .cd_big_endian(cd_big_endian),
        .cd_record(cd_record), .cd_tbi(cd_tbi), .cd_asid(cd_asid), .cd_ips(cd_ips),
        .max_ips(max_ips), .cd_walk_dis(cd_walk_dis), .cd_tsz0(cd_tsz0), .cd_tsz1(cd_tsz1),
        .cd_tg0(cd_tg0), .cd_tg1(cd_tg1), .cd_ttb0(cd_ttb0), .cd_ttb1(cd_ttb1),
        .out_vld(out_vld), .cfg_ok(cfg_ok), .bad_cd_evt(bad_cd_evt), .oas_bits(oas_bits),
        .tbi_o(tbi_o), .asid_o(asid_o), .record_o(record_o), .tt_dis(tt_dis),
        .tsz0(tsz0), .tsz1(tsz1), .gran0(gran0), .gran1(gran1), .base0(base0), .base1(base1)
    );

    task automatic chk(input logic cond, input string req, input longint act, input longint exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_good();
        cd_valid = 1; cd_fmt64 = 1; cd_abort = 1; cd_stall = 0; cd_hw_af = 0; cd_hw_dirty = 0;
        cd_big_endian = 0; cd_record = 1; cd_tbi = 2'b01; cd_asid = 16'h1234;
        cd_ips = 3'd5; max_ips = 3'd5; cd_walk_dis = 2'b00;
        cd_tsz0 = 6'd25; cd_tsz1 = 6'd25; cd_tg0 = 2'd0; cd_tg1 = 2'd2;
        cd_ttb0 = 52'h1000; cd_ttb1 = 52'h2000;
    endtask

    task automatic apply();
        @(negedge clk);
        in_vld = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_vld = 1'b0;
    endtask

    task automatic verdict(input logic ok_exp, input string req);
        chk(out_vld == 1'b1, req, out_vld, 1);
        chk(cfg_ok == ok_exp && bad_cd_evt == !ok_exp, req, {cfg_ok, bad_cd_evt}, {ok_exp, !ok_exp});
    endtask

    task automatic t_reset();
        chk(!out_vld && !cfg_ok && !bad_cd_evt, "R1 reset", {out_vld, cfg_ok, bad_cd_evt}, 0);
    endtask

    task automatic t_good();
        set_good(); apply();
        verdict(1'b1, "R1 good");
        chk(oas_bits == 6'd48, "R4 oas48", oas_bits, 48);
        chk(tbi_o == 2'b01, "R10 tbi", tbi_o, 1);
        chk(asid_o == 16'h1234, "R10 asid", asid_o, 16'h1234);
        chk(record_o == 1'b1, "R10 record", record_o, 1);
        chk(gran0 == 5'd12 && gran1 == 5'd12, "R7 4k both", {gran0, gran1}, {5'd12, 5'd12});
        chk(base0 == 52'h1000 && tsz1 == 6'd25, "R10 passthru", base0, 52'h1000);
        set_good(); cd_record = 0; cd_tbi = 2'b10; cd_asid = 16'hBEEF; apply();
        chk(record_o == 1'b0 && tbi_o == 2'b10 && asid_o == 16'hBEEF, "R10 second",
            {record_o, tbi_o, asid_o}, {1'b0, 2'b10, 16'hBEEF});
    endtask

    task automatic t_header();
        set_good(); cd_valid = 0; apply(); verdict(1'b0, "R2 invalid");
        set_good(); cd_fmt64 = 0; apply(); verdict(1'b0, "R2 fmt");
        set_good(); cd_abort = 0; apply(); verdict(1'b0, "R3 abort");
        set_good(); cd_stall = 1; apply(); verdict(1'b0, "R3 stall");
        set_good(); cd_hw_af = 1; apply(); verdict(1'b0, "R3 af");
        set_good(); cd_hw_dirty = 1; apply(); verdict(1'b0, "R3 dirty");
    endtask

    task automatic t_oas();
        set_good(); cd_ips = 3'd2; max_ips = 3'd5; apply();
        chk(oas_bits == 6'd40, "R4 ips2", oas_bits, 40);
        set_good(); cd_ips = 3'd6; max_ips = 3'd3; apply();
        chk(oas_bits == 6'd42, "R4 clamp", oas_bits, 42);
        set_good(); cd_ips = 3'd7; max_ips = 3'd6; apply();
        chk(oas_bits == 6'd48, "R4 code7", oas_bits, 48);
        set_good(); cd_ips = 3'd6; max_ips = 3'd6; apply();
        chk(oas_bits == 6'd52, "R4 52", oas_bits, 52);
        set_good(); cd_ips = 3'd1; max_ips = 3'd4; apply();
        chk(oas_bits == 6'd36, "R4 36", oas_bits, 36);
    endtask

    task automatic t_tsz();
        set_good(); cd_tsz0 = 6'd15; apply(); verdict(1'b0, "R6 tsz15");
        set_good(); cd_tsz0 = 6'd16; apply(); verdict(1'b1, "R6 tsz16");
        set_good(); cd_tsz0 = 6'd39; apply(); verdict(1'b1, "R6 tsz39");
        set_good(); cd_tsz0 = 6'd40; apply(); verdict(1'b0, "R6 tsz40");
        set_good(); cd_tsz1 = 6'd40; apply(); verdict(1'b0, "R6 tsz1 40");
    endtask

    task automatic t_gran();
        set_good(); cd_tg0 = 2'd2; apply(); verdict(1'b0, "R7 t0 16k");
        chk(gran0 == 5'd14, "R7 t0 16k code", gran0, 14);
        set_good(); cd_tg0 = 2'd1; apply(); verdict(1'b1, "R7 t0 64k");
        chk(gran0 == 5'd16, "R7 t0 64k code", gran0, 16);
        set_good(); cd_tg0 = 2'd3; apply(); verdict(1'b0, "R7 t0 bad");
        chk(gran0 == 5'd0, "R7 t0 bad code", gran0, 0);
        set_good(); cd_tg1 = 2'd3; apply(); verdict(1'b1, "R7 t1 64k");
        chk(gran1 == 5'd16, "R7 t1 64k code", gran1, 16);
        set_good(); cd_tg1 = 2'd1; apply(); verdict(1'b0, "R7 t1 16k");
        chk(gran1 == 5'd14, "R7 t1 16k code", gran1, 14);
        set_good(); cd_tg1 = 2'd0; apply(); verdict(1'b0, "R7 t1 bad");
        chk(gran1 == 5'd0, "R7 t1 bad code", gran1, 0);
    endtask

    task automatic t_disable();
        set_good(); cd_walk_dis = 2'b01; cd_tsz0 = 6'd0; cd_tg0 = 2'd3; cd_ttb0 = '1; apply();
        verdict(1'b1, "R5 t0 off");
        chk(tt_dis == 2'b01, "R5 flag", tt_dis, 1);
        set_good(); cd_walk_dis = 2'b10; cd_tsz1 = 6'd63; cd_tg1 = 2'd0; apply();
        verdict(1'b1, "R5 t1 off");
        set_good(); cd_walk_dis = 2'b10; cd_tsz0 = 6'd10; apply();
        verdict(1'b0, "R5 other still checked");
    endtask

    task automatic t_endian();
        set_good(); cd_big_endian = 1; apply(); verdict(1'b0, "R8 endian");
        set_good(); cd_big_endian = 1; cd_walk_dis = 2'b01; apply(); verdict(1'b0, "R8 one on");
        set_good(); cd_big_endian = 1; cd_walk_dis = 2'b11; apply(); verdict(1'b1, "R8 both off");
    endtask

    task automatic t_base();
        set_good(); cd_ips = 3'd0; cd_ttb0 = 52'h1_0000_0000; apply(); verdict(1'b0, "R9 t0 bit32");
        set_good(); cd_ips = 3'd0; cd_ttb0 = 52'h0_FFFF_F000; apply(); verdict(1'b1, "R9 t0 fits");
        set_good(); cd_ips = 3'd0; cd_ttb1 = 52'h8_0000_0000; apply(); verdict(1'b0, "R9 t1 high");
        set_good(); cd_ips = 3'd6; max_ips = 3'd2; cd_ttb0 = 52'h100_0000_0000; apply();
        verdict(1'b0, "R9 clamped size");
    endtask

    task automatic t_hold();
        set_good(); apply();
        @(negedge clk);
        cd_ips = 3'd0; cd_ttb0 = 52'hABC000; cd_walk_dis = 2'b11;
        @(negedge clk);
        chk(!out_vld && !cfg_ok && !bad_cd_evt, "R1 idle", {out_vld, cfg_ok, bad_cd_evt}, 0);
        chk(oas_bits == 6'd48 && base0 == 52'h1000 && tt_dis == 2'b00, "R1 hold",
            base0, 52'h1000);
    endtask

    initial begin
        set_good();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_good();
        t_header();
        t_oas();
        t_tsz();
        t_gran();
        t_disable();
        t_endian();
        t_base();
        t_hold();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule